// File: doc/BRIEF.md
# Emulated Internal Shared Bus Resolver

This block replaces a shared internal bus that several sources would drive through tri-state buffers. Each of `N_SRC` sources presents a data word and an output-enable. The block combines them with ordinary gates into one resolved bus word, so the chip never carries a high-impedance net.

The case where no enable is active and the case where several are active both resolve to fixed levels. An idle bus reads as all ones, much like a bus held up by a pull-up. A contended bus reads as all zeros. The block also raises a flag for each of these two cases. It has no clock and no state. Its outputs follow its inputs within the same cycle.

Top module: `emu_tristate_bus`

## Requirements
- R1: When exactly one bit of `src_oe_i` is set, `bus_o` equals that source's data word. Source k's word is `src_data_i[k*DATA_W +: DATA_W]`.
- R2: When two or more bits of `src_oe_i` are set, `bus_o` is all zeros, whatever the data words hold.
- R3: When no bit of `src_oe_i` is set, `bus_o` is all ones, whatever the data words hold.
- R4: `contention_o` is 1 exactly when two or more enables are set, and 0 otherwise.
- R5: `idle_o` is 1 exactly when no enable is set, and 0 otherwise.
- R6: For every fully known input pattern, `bus_o`, `contention_o` and `idle_o` hold no X or Z bits.
- R7: The outputs are a pure function of the present inputs. A new input pattern shows on the outputs in the same cycle it is applied, and the history of earlier patterns has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_data_i | input | N_SRC*DATA_W | Packed data words; source k in slice k*DATA_W +: DATA_W |
| src_oe_i | input | N_SRC | Output-enable per source, bit k for source k |
| bus_o | output | DATA_W | Resolved bus word |
| contention_o | output | 1 | Two or more enables active |
| idle_o | output | 1 | No enable active |

## Verification
The checker assumes that every enable bit and data bit is a known 0 or 1. It also assumes that it samples the inputs only after they have settled, because the block has no clock to mark when a value is valid. The bench meets both assumptions. It always drives fully defined values, it changes them only on the rising edge of its clock, and it reads the outputs on the falling edge. The stimulus walks through every enable pattern and then random ones. Both kinds use random data words, so the fixed all-zeros and all-ones results cannot match by chance.

// File: rtl/emu_tristate_bus_pkg.sv
package emu_tristate_bus_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE    = 2'd0,
    BUS_SINGLE  = 2'd1,
    BUS_CONTEND = 2'd2
  } bus_state_e;
endpackage

// File: rtl/ebus_oe_classify.sv
module ebus_oe_classify
  import emu_tristate_bus_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] oe_i,
  output bus_state_e       state_o
);
  logic [N_SRC-1:0] low_cleared;
  logic             any_en, many_en;

  // clearing the lowest set bit leaves something only if >=2 bits were set
  assign low_cleared = oe_i & (oe_i - N_SRC'(1));
  assign any_en      = |oe_i;
  assign many_en     = |low_cleared;

  always_comb begin
    if (!any_en)      state_o = BUS_IDLE;
    else if (many_en) state_o = BUS_CONTEND;
    else              state_o = BUS_SINGLE;
  end
endmodule

// File: rtl/ebus_and_or_mux.sv
module ebus_and_or_mux #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_SRC*DATA_W-1:0] data_i,
  input  logic [N_SRC-1:0]        oe_i,
  output logic [DATA_W-1:0]       data_o
);
  logic [DATA_W-1:0] gated [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = data_i[g*DATA_W +: DATA_W] & {DATA_W{oe_i[g]}};
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_SRC; i++) data_o |= gated[i];
  end
endmodule

// File: rtl/ebus_resolve.sv
module ebus_resolve
  import emu_tristate_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  bus_state_e        state_i,
  input  logic [DATA_W-1:0] muxed_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              contention_o,
  output logic              idle_o
);
  always_comb begin
    unique case (state_i)
      BUS_IDLE:    bus_o = '1;
      BUS_SINGLE:  bus_o = muxed_i;
      default:     bus_o = '0;
    endcase
  end

  assign contention_o = (state_i == BUS_CONTEND);
  assign idle_o       = (state_i == BUS_IDLE);
endmodule

// File: rtl/emu_tristate_bus.sv
module emu_tristate_bus
  import emu_tristate_bus_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_SRC*DATA_W-1:0] src_data_i,
  input  logic [N_SRC-1:0]        src_oe_i,
  output logic [DATA_W-1:0]       bus_o,
  output logic                    contention_o,
  output logic                    idle_o
);
  bus_state_e        state;
  logic [DATA_W-1:0] muxed;

  ebus_oe_classify #(.N_SRC(N_SRC)) classify_i (
    .oe_i    (src_oe_i),
    .state_o (state)
  );

  ebus_and_or_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W)) mux_i (
    .data_i (src_data_i),
    .oe_i   (src_oe_i),
    .data_o (muxed)
  );

  ebus_resolve #(.DATA_W(DATA_W)) resolve_i (
    .state_i      (state),
    .muxed_i      (muxed),
    .bus_o        (bus_o),
    .contention_o (contention_o),
    .idle_o       (idle_o)
  );
endmodule

// File: rtl/emu_tristate_bus_chk.sv
module emu_tristate_bus_chk #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic [N_SRC*DATA_W-1:0] src_data_i,
  input logic [N_SRC-1:0]        src_oe_i,
  input logic [DATA_W-1:0]       bus_o,
  input logic                    contention_o,
  input logic                    idle_o
);
  always_comb begin
    if (!$isunknown({src_data_i, src_oe_i})) begin
      int n_en;
      int sel;
      n_en = $countones(src_oe_i);
      sel  = 0;
      for (int i = 0; i < N_SRC; i++) if (src_oe_i[i]) sel = i;
      p_single_pass_r1: assert (n_en != 1 || bus_o == src_data_i[sel*DATA_W +: DATA_W]);
      p_contend_low_r2: assert (n_en < 2 || bus_o == '0);
      p_idle_high_r3:   assert (n_en != 0 || bus_o == '1);
      p_contend_flag_r4: assert (contention_o == (n_en >= 2));
      p_idle_flag_r5:   assert (idle_o == (n_en == 0));
      p_known_out_r6:   assert (!$isunknown({bus_o, contention_o, idle_o}));
    end
  end
endmodule

bind emu_tristate_bus emu_tristate_bus_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) chk_i (
  .src_data_i   (src_data_i),
  .src_oe_i     (src_oe_i),
  .bus_o        (bus_o),
  .contention_o (contention_o),
  .idle_o       (idle_o)
);

// File: tb/emu_tristate_bus_tb_top.sv
module emu_tristate_bus_tb_top;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned DATA_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [N_SRC*DATA_W-1:0] src_data_i = '0;
  logic [N_SRC-1:0]        src_oe_i   = '0;
  logic [DATA_W-1:0]       bus_o;
  logic                    contention_o, idle_o;

  int total = 0;
  int bad   = 0;

  emu_tristate_bus #(.N_SRC(N_SRC), .DATA_W(DATA_W)) dut_i (
    .src_data_i   (src_data_i),
    .src_oe_i     (src_oe_i),
    .bus_o        (bus_o),
    .contention_o (contention_o),
    .idle_o       (idle_o)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h oe=%b", req, act, exp, src_oe_i);
    end
  endtask

  // behavioural reference, compared at the falling edge
  task automatic compare();
    int cnt = 0;
    logic [DATA_W-1:0] exp_bus = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_oe_i[i]) begin
        cnt++;
        exp_bus = src_data_i[i*DATA_W +: DATA_W];
      end
    end
    if (cnt == 0) chk("R3 idle bus", bus_o, '1);
    else if (cnt == 1) chk("R1 single driver", bus_o, exp_bus);
    else chk("R2 contention", bus_o, '0);
    chk("R4 contention flag", DATA_W'(contention_o), DATA_W'(cnt >= 2));
    chk("R5 idle flag", DATA_W'(idle_o), DATA_W'(cnt == 0));
    chk("R6 known outputs", DATA_W'($isunknown({bus_o, contention_o, idle_o})), '0);
  endtask

  task automatic apply(input logic [N_SRC-1:0] oe, input logic [N_SRC*DATA_W-1:0] d);
    @(posedge clk);
    src_oe_i   <= oe;
    src_data_i <= d;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [N_SRC*DATA_W-1:0] rnd_data();
    logic [N_SRC*DATA_W-1:0] v;
    for (int i = 0; i < N_SRC; i++) v[i*DATA_W +: DATA_W] = DATA_W'($urandom);
    return v;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare(); // reset-time state: nothing enabled, R3/R5
    // every enable pattern with several data sets
    for (int rep = 0; rep < 4; rep++)
      for (int p = 0; p < (1 << N_SRC); p++)
        apply(N_SRC'(p), rnd_data());
    // idle bus must not leak data of zeros: R3
    apply('0, '0);
    // contention with all-ones data: R2
    apply('1, '1);
    // R7: same data, enable flips between cycles; no history effect
    begin
      logic [N_SRC*DATA_W-1:0] d = rnd_data();
      apply(N_SRC'(1), d);
      apply(N_SRC'(3), d);
      apply(N_SRC'(1), d);
      chk("R7 no history", bus_o, d[DATA_W-1:0]);
    end
    for (int k = 0; k < 400; k++) apply(N_SRC'($urandom), rnd_data());
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule